// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Byte Lanes

This block is a true dual-port static memory. Each of its two ports has its own clock and reaches the whole array. A word is 18 bits wide and splits into two 9-bit byte lanes. Each port samples its address, write data, read/write select, two chip enables and two lane selects on the rising edge of its own clock. A static mode input per port picks how reads come out. In flow-through mode the word shows up after the capturing edge. In pipelined mode it shows up one edge later.

The tri-state pins are modelled as a data bus plus one drive-enable bit per lane. A lane that is not driven reads as zero on the data bus. An output-enable input gates the drive bits with no clock involved. The two ports may run at unrelated clock rates and touch any locations at the same time. When both ports write one address in overlapping cycles, the stored result is undefined. Addresses come from outside the block; counters live elsewhere.

The depth is set by the parameter `ADDR_W`. The default of 11 gives 2K words, and 13 gives the full 8K configuration.

Top module: `dpr_byte_lane_ram`

## Requirements
- R1: A port is selected when `enLowN` is 0 and `enHigh` is 1. A selected port with `rdWrN` = 0 writes, at that clock edge, only the lanes whose active-low select is 0. `laneSelN[0]` guards bits 8..0 and `laneSelN[1]` guards bits 17..9. Unselected lanes keep their old contents.
- R2: A selected write with both lane selects at 1 changes no stored bit. A selected read with both lane selects at 1 drives neither lane.
- R3: With `enLowN` = 1 or `enHigh` = 0, a port writes nothing. In flow-through mode it drives no lane after that edge.
- R4: In flow-through mode (`pipe` = 0), a selected read captured at edge n drives the selected lanes with the addressed word from edge n until edge n+1.
- R5: In pipelined mode (`pipe` = 1), the same read data and drive appear from edge n+1 until edge n+2.
- R6: In pipelined mode, selection and the read/write choice pass through two register stages. A read captured at edge n still drives after edge n+1 even if the port was deselected at edge n+1. A deselect at edge n stops driving only after edge n+1.
- R7: In both modes the lane drive after edge k follows the lane selects sampled at edge k, through one register only.
- R8: While `oeN` is 1, both drive bits of that port are 0 immediately, without a clock edge. Releasing it restores the drive at once.
- R9: Both ports operate at the same time on independent clocks. A word written by one port reads back correctly on the other. One port can read while the other writes a different address.
- R10: While `rstN` is 0, and after release until a read is issued, no lane of either port is driven. Lanes that are not driven show 0 on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Clock of port A |
| clkB | input | 1 | Clock of port B |
| rstN | input | 1 | Asynchronous active-low reset of the control registers |
| addrA | input | ADDR_W | Port A word address |
| dinA | input | 18 | Port A write data |
| rdWrNA | input | 1 | Port A: 1 read, 0 write |
| enLowNA | input | 1 | Port A active-low chip enable |
| enHighA | input | 1 | Port A active-high chip enable |
| laneSelNA | input | 2 | Port A active-low lane selects, bit 1 upper lane |
| oeNA | input | 1 | Port A active-low asynchronous output enable |
| pipeA | input | 1 | Port A output mode: 0 flow-through, 1 pipelined |
| doutA | output | 18 | Port A read data, zero on lanes not driven |
| driveA | output | 2 | Port A per-lane drive enable, bit 1 upper lane |
| addrB | input | ADDR_W | Port B word address |
| dinB | input | 18 | Port B write data |
| rdWrNB | input | 1 | Port B: 1 read, 0 write |
| enLowNB | input | 1 | Port B active-low chip enable |
| enHighB | input | 1 | Port B active-high chip enable |
| laneSelNB | input | 2 | Port B active-low lane selects, bit 1 upper lane |
| oeNB | input | 1 | Port B active-low asynchronous output enable |
| pipeB | input | 1 | Port B output mode: 0 flow-through, 1 pipelined |
| doutB | output | 18 | Port B read data, zero on lanes not driven |
| driveB | output | 2 | Port B per-lane drive enable, bit 1 upper lane |

## Verification
The hardest case to reach is the pipelined deselect. There, a read still drives its lanes one edge after the port has been turned off, while the lane selects have already moved on. The stimulus sets this up by issuing a read with one lane select and then deselecting with the other lane select. The per-cycle reference model then expects the old data on whatever lanes the newer select allows. The second hard case is a read on one port that overlaps a write on the other port while the two clocks drift against each other. Two unrelated clock periods and disjoint address ranges produce that overlap, and later cross reads confirm that each port sees the other's writes.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  // strobes handed from a port's control to the shared datapath
  typedef struct packed {
    logic [LANES-1:0] laneWr;     // lanes written at this edge
    logic [LANES-1:0] laneDrive;  // lanes presented on the outputs now
    logic             pipeSel;    // take read data from the second stage
  } portStrobe_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
`timescale 1ns/1ps
module dpr_port_ctrl
  import dpr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enLowN,
  input  logic             enHigh,
  input  logic             rdWrN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             oeN,
  input  logic             pipeMode,
  output portStrobe_t      strobe
);
  logic             portSel;
  logic             rdAct1;
  logic             rdAct2;
  logic [LANES-1:0] laneSelQ;
  logic             actSel;
  logic [LANES-1:0] laneDriveC;

  assign portSel = !enLowN && enHigh;

  // selection is carried two deep, lane selects only one deep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAct1   <= 1'b0;
      rdAct2   <= 1'b0;
      laneSelQ <= '1;
    end else begin
      rdAct1   <= portSel && rdWrN;
      rdAct2   <= rdAct1;
      laneSelQ <= laneSelN;
    end
  end

  assign actSel     = pipeMode ? rdAct2 : rdAct1;
  assign laneDriveC = {LANES{actSel && !oeN}} & ~laneSelQ;

  assign strobe.laneWr    = (portSel && !rdWrN) ? ~laneSelN : '0;
  assign strobe.laneDrive = laneDriveC;
  assign strobe.pipeSel   = pipeMode;

  // edges seen since reset, saturating, so $past never reaches before reset
  logic [1:0] histCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histCnt <= 2'd0;
    else if (histCnt != 2'd2) histCnt <= histCnt + 2'd1;
  end

  AST_FT_DESELECT: assert property (@(posedge clk) disable iff (!rstN) (histCnt != 2'd0 && !pipeMode && !$past(portSel)) |-> laneDriveC == '0) else $error("flow-through drive after deselect"); // R3
  AST_PIPE_DESELECT: assert property (@(posedge clk) disable iff (!rstN) (histCnt == 2'd2 && pipeMode && !$past(portSel, 2)) |-> laneDriveC == '0) else $error("pipelined drive two edges after deselect"); // R6
  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (histCnt == 2'd2 && pipeMode && !oeN && $past(portSel && rdWrN, 2)) |-> laneDriveC == ~$past(laneSelN)) else $error("pipelined read lost its drive"); // R6
  AST_LANE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) (histCnt != 2'd0) |-> (laneDriveC & $past(laneSelN)) == '0) else $error("lane driven against its select"); // R7
endmodule

// File: rtl/dpr_datapath.sv
`timescale 1ns/1ps
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [WORD_W-1:0] dinA,
  input  logic [WORD_W-1:0] dinB,
  input  portStrobe_t       strobeA,
  input  portStrobe_t       strobeB,
  output logic [WORD_W-1:0] doutA,
  output logic [WORD_W-1:0] doutB
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PORTS = 2;

  // each bank has one writer; a word is the XOR of both banks
  logic [WORD_W-1:0] bankA [DEPTH];
  logic [WORD_W-1:0] bankB [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bankA[i] = '0;
      bankB[i] = '0;
    end
  end

  always_ff @(posedge clkA) begin
    for (int l = 0; l < LANES; l++)
      if (strobeA.laneWr[l])
        bankA[addrA][l*LANE_W +: LANE_W] <= dinA[l*LANE_W +: LANE_W] ^ bankB[addrA][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clkB) begin
    for (int l = 0; l < LANES; l++)
      if (strobeB.laneWr[l])
        bankB[addrB][l*LANE_W +: LANE_W] <= dinB[l*LANE_W +: LANE_W] ^ bankA[addrB][l*LANE_W +: LANE_W];
  end

  logic              pClk  [PORTS];
  logic [ADDR_W-1:0] pAddr [PORTS];
  portStrobe_t       pStb  [PORTS];
  logic [WORD_W-1:0] pOut  [PORTS];

  assign pClk[0]  = clkA;
  assign pClk[1]  = clkB;
  assign pAddr[0] = addrA;
  assign pAddr[1] = addrB;
  assign pStb[0]  = strobeA;
  assign pStb[1]  = strobeB;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [WORD_W-1:0] stage1;
    logic [WORD_W-1:0] stage2;
    logic [WORD_W-1:0] rdSel;

    always_ff @(posedge pClk[p]) begin
      stage1 <= bankA[pAddr[p]] ^ bankB[pAddr[p]];
      stage2 <= stage1;
    end

    assign rdSel = pStb[p].pipeSel ? stage2 : stage1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign pOut[p][l*LANE_W +: LANE_W] = pStb[p].laneDrive[l] ? rdSel[l*LANE_W +: LANE_W] : '0;
    end
  end

  assign doutA = pOut[0];
  assign doutB = pOut[1];
endmodule

// File: rtl/dpr_byte_lane_ram.sv
`timescale 1ns/1ps
module dpr_byte_lane_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [WORD_W-1:0] dinA,
  input  logic              rdWrNA,
  input  logic              enLowNA,
  input  logic              enHighA,
  input  logic [LANES-1:0]  laneSelNA,
  input  logic              oeNA,
  input  logic              pipeA,
  output logic [WORD_W-1:0] doutA,
  output logic [LANES-1:0]  driveA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [WORD_W-1:0] dinB,
  input  logic              rdWrNB,
  input  logic              enLowNB,
  input  logic              enHighB,
  input  logic [LANES-1:0]  laneSelNB,
  input  logic              oeNB,
  input  logic              pipeB,
  output logic [WORD_W-1:0] doutB,
  output logic [LANES-1:0]  driveB
);
  portStrobe_t strobeA;
  portStrobe_t strobeB;

  dpr_port_ctrl u_ctrlA (
    .clk(clkA), .rstN(rstN), .enLowN(enLowNA), .enHigh(enHighA), .rdWrN(rdWrNA),
    .laneSelN(laneSelNA), .oeN(oeNA), .pipeMode(pipeA), .strobe(strobeA)
  );

  dpr_port_ctrl u_ctrlB (
    .clk(clkB), .rstN(rstN), .enLowN(enLowNB), .enHigh(enHighB), .rdWrN(rdWrNB),
    .laneSelN(laneSelNB), .oeN(oeNB), .pipeMode(pipeB), .strobe(strobeB)
  );

  dpr_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clkA(clkA), .clkB(clkB), .addrA(addrA), .addrB(addrB), .dinA(dinA), .dinB(dinB),
    .strobeA(strobeA), .strobeB(strobeB), .doutA(doutA), .doutB(doutB)
  );

  assign driveA = strobeA.laneDrive;
  assign driveB = strobeB.laneDrive;
endmodule

// File: tb/dpr_byte_lane_ram_tb.sv
`timescale 1ns/1ps
module dpr_byte_lane_ram_tb;
  localparam int AW = 11;
  localparam int IDLE = 0, IDLE1 = 1, RD = 2, WR = 3, WRX = 4;

  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clkA = ~clkA;   // 200 MHz
  always #3.5 clkB = ~clkB;   // unrelated second clock

  logic [AW-1:0] addrV [2];
  logic [17:0]   dinV  [2];
  logic          rwV   [2];
  logic          enLowNV [2];
  logic          enHighV [2];
  logic          oeNV  [2];
  logic          pipeV [2];
  logic [1:0]    lsV   [2];
  logic [17:0]   doutA, doutB;
  logic [1:0]    driveA, driveB;

  dpr_byte_lane_ram #(.ADDR_W(AW)) u_dut (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .addrA(addrV[0]), .dinA(dinV[0]), .rdWrNA(rwV[0]), .enLowNA(enLowNV[0]), .enHighA(enHighV[0]),
    .laneSelNA(lsV[0]), .oeNA(oeNV[0]), .pipeA(pipeV[0]), .doutA(doutA), .driveA(driveA),
    .addrB(addrV[1]), .dinB(dinV[1]), .rdWrNB(rwV[1]), .enLowNB(enLowNV[1]), .enHighB(enHighV[1]),
    .laneSelNB(lsV[1]), .oeNB(oeNV[1]), .pipeB(pipeV[1]), .doutB(doutB), .driveB(driveB)
  );

  // behavioural reference model
  logic [17:0] refMem [int];
  bit          act1 [2];
  bit          act2 [2];
  logic [17:0] d1   [2];
  logic [17:0] d2   [2];
  logic [1:0]  lq   [2];
  string       curReq [2];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [17:0] pat(input int a, input int s);
    return 18'((a * 1297 + s * 331) ^ (a << 9));
  endfunction

  task automatic modelEdge(input int p);
    logic        sel;
    logic [17:0] w;
    int          a;
    if (!rstN) begin
      act1[p] = 0; act2[p] = 0; lq[p] = 2'b11;
      return;
    end
    a   = int'(addrV[p]);
    sel = !enLowNV[p] && enHighV[p];
    act2[p] = act1[p];
    d2[p]   = d1[p];
    act1[p] = sel && rwV[p];
    d1[p]   = refMem.exists(a) ? refMem[a] : 18'hx;
    lq[p]   = lsV[p];
    if (sel && !rwV[p]) begin
      w = refMem.exists(a) ? refMem[a] : 18'hx;
      for (int l = 0; l < 2; l++)
        if (!lsV[p][l]) w[l*9 +: 9] = dinV[p][l*9 +: 9];
      refMem[a] = w;
    end
  endtask

  task automatic checkPort(input int p, input logic [1:0] drv, input logic [17:0] dq);
    bit          act;
    logic [1:0]  expDrv;
    logic [17:0] expDat;
    logic [17:0] src;
    act    = pipeV[p] ? act2[p] : act1[p];
    src    = pipeV[p] ? d2[p] : d1[p];
    expDrv = (act && !oeNV[p]) ? ~lq[p] : 2'b00;
    expDat = '0;
    for (int l = 0; l < 2; l++)
      if (expDrv[l]) expDat[l*9 +: 9] = src[l*9 +: 9];
    checks++;
    if (drv !== expDrv || dq !== expDat) begin
      fails++;
      $display("FAIL %s port %0d: drive=%b data=%h expected drive=%b data=%h",
               curReq[p], p, drv, dq, expDrv, expDat);
    end
  endtask

  always @(posedge clkA) modelEdge(0);
  always @(posedge clkB) modelEdge(1);
  always @(negedge clkA) if (!done) checkPort(0, driveA, doutA);
  always @(negedge clkB) if (!done) checkPort(1, driveB, doutB);

  task automatic portOp(input int p, input int kind, input int addr, input logic [17:0] d,
                        input logic [1:0] ls, input string req);
    if (p == 0) @(negedge clkA); else @(negedge clkB);
    #1;
    curReq[p]  = req;
    addrV[p]   = addr[AW-1:0];
    dinV[p]    = d;
    lsV[p]     = ls;
    rwV[p]     = 1'b1;
    enLowNV[p] = 1'b0;
    enHighV[p] = 1'b1;
    case (kind)
      IDLE:  enLowNV[p] = 1'b1;
      IDLE1: enHighV[p] = 1'b0;
      WR:    rwV[p] = 1'b0;
      WRX:   begin rwV[p] = 1'b0; enLowNV[p] = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic idleN(input int p, input int n, input string req);
    for (int i = 0; i < n; i++) portOp(p, IDLE, 0, '0, 2'b11, req);
  endtask

  task automatic explicitCheck(input bit cond, input string req, input logic [1:0] act, input logic [1:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: drive=%b expected %b", req, act, expv);
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      addrV[p] = '0; dinV[p] = '0; rwV[p] = 1'b1; enLowNV[p] = 1'b1; enHighV[p] = 1'b1;
      oeNV[p] = 1'b0; lsV[p] = 2'b11; curReq[p] = "R10";
    end
    pipeV[0] = 1'b0;
    pipeV[1] = 1'b1;

    // R10: nothing driven in reset
    repeat (4) @(negedge clkA);
    #1;
    explicitCheck(driveA === 2'b00 && driveB === 2'b00 && doutA === '0 && doutB === '0,
                  "R10 reset", driveA | driveB, 2'b00);
    rstN = 1'b1;
    idleN(0, 2, "R10");

    // R1: full-word writes on both ports at once
    fork
      for (int i = 0; i < 16; i++) portOp(0, WR, i, pat(i, 1), 2'b00, "R1");
      for (int i = 64; i < 80; i++) portOp(1, WR, i, pat(i, 2), 2'b00, "R1");
    join
    // R4 on port A (flow-through), R5 on port B (pipelined)
    fork
      begin for (int i = 0; i < 16; i++) portOp(0, RD, i, '0, 2'b00, "R4"); idleN(0, 3, "R4"); end
      begin for (int i = 64; i < 80; i++) portOp(1, RD, i, '0, 2'b00, "R5"); idleN(1, 3, "R5"); end
    join

    // R1/R2: lane writes, then read back full words
    portOp(0, WR, 3, 18'h3FFFF, 2'b10, "R1");
    portOp(0, WR, 4, 18'h3FFFF, 2'b01, "R1");
    portOp(0, WR, 5, 18'h3FFFF, 2'b11, "R2");
    portOp(0, RD, 3, '0, 2'b00, "R1");
    portOp(0, RD, 4, '0, 2'b00, "R1");
    portOp(0, RD, 5, '0, 2'b00, "R2");
    portOp(0, RD, 6, '0, 2'b11, "R2");
    idleN(0, 2, "R2");

    // R9: B reads A's words while A writes elsewhere, then cross reads
    fork
      for (int i = 128; i < 144; i++) portOp(0, WR, i, pat(i, 3), 2'b00, "R9");
      for (int i = 0; i < 16; i++) portOp(1, RD, i, '0, 2'b00, "R9");
    join
    fork
      begin for (int i = 64; i < 80; i++) portOp(0, RD, i, '0, 2'b00, "R9"); idleN(0, 3, "R9"); end
      begin for (int i = 128; i < 144; i++) portOp(1, RD, i, '0, 2'b00, "R9"); idleN(1, 3, "R9"); end
    join

    // R7: lane selects single-buffered in both modes
    fork
      begin
        for (int i = 0; i < 6; i++) portOp(0, RD, i, '0, 2'(i % 3 + 1), "R7");
        idleN(0, 2, "R7");
      end
      begin
        for (int i = 64; i < 70; i++) portOp(1, RD, i, '0, 2'(i % 3 + 1), "R7");
        portOp(1, RD, 70, '0, 2'b10, "R7");
        portOp(1, IDLE, 0, '0, 2'b01, "R7");
        idleN(1, 2, "R7");
      end
    join

    // R6: pipelined read outlives the following deselect; R3: flow-through does not
    fork
      begin
        portOp(1, RD, 71, '0, 2'b00, "R6");
        portOp(1, IDLE1, 0, '0, 2'b00, "R6");
        portOp(1, IDLE, 0, '0, 2'b00, "R6");
        idleN(1, 2, "R6");
      end
      begin
        portOp(0, RD, 1, '0, 2'b00, "R3");
        portOp(0, IDLE1, 0, '0, 2'b00, "R3");
        portOp(0, WRX, 2, 18'h15555, 2'b00, "R3");
        portOp(0, RD, 2, '0, 2'b00, "R3");
        idleN(0, 2, "R3");
      end
    join

    // R8: output enable acts without a clock edge
    portOp(0, RD, 7, '0, 2'b00, "R8");
    @(negedge clkA);
    #1 oeNV[0] = 1'b1;
    #0.5 explicitCheck(driveA === 2'b00 && doutA === '0, "R8 oe high", driveA, 2'b00);
    oeNV[0] = 1'b0;
    #0.5 explicitCheck(driveA === 2'b11 && doutA === pat(7, 1), "R8 oe low", driveA, 2'b11);
    idleN(0, 3, "R8");

    // swap modes: A pipelined, B flow-through
    fork idleN(0, 3, "R5"); idleN(1, 3, "R4"); join
    @(negedge clkA);
    #1 pipeV[0] = 1'b1; pipeV[1] = 1'b0;
    fork
      begin
        for (int i = 128; i < 144; i++) portOp(0, RD, i, '0, 2'(i % 4), "R5");
        idleN(0, 3, "R5");
      end
      begin
        for (int i = 0; i < 16; i++) portOp(1, RD, i, '0, 2'(i % 4), "R4");
        portOp(1, RD, 3, '0, 2'b00, "R3");
        portOp(1, IDLE1, 0, '0, 2'b00, "R3");
        idleN(1, 3, "R4");
      end
    join

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clkA);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run still active (actual hung, expected finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule